// File: doc/BRIEF.md
# Byte-Lane Transfer Splitter

This block takes one byte or word access from an internal requester and turns it into one or two cycles on an external data bus. In the default 16-bit mode the bus has two 8-bit banks. The even bank sits on the low lane and is enabled when address bit 0 is 0. The odd bank sits on the high lane and is enabled when the active-low high-bank enable is 0. For each cycle the block works out the address, the lane enables and the lane routing. It moves write bytes onto the lane in use. On reads it gathers the returned bytes into one right-justified result.

A word at an odd address is split into two ordered cycles. The first moves the odd byte on the high lane. The second moves the following byte on the low lane, at the next even address. When the mode input selects an 8-bit bus, every byte travels on the low lane. A word then becomes two byte cycles, the low byte first. Each external cycle is a request/done handshake with an outside bus sequencer. The requester holds its request until a one-cycle acknowledge arrives, and read data is valid in that acknowledge cycle.

Top module: `byte_lane_splitter`

## Requirements
- R1: In 16-bit mode an even-address byte access takes one cycle with cyc_addr_o[0]=0 and cyc_bhe_no=1. A write drives the byte on both lanes, and a read returns {8'h00, bus[7:0]}.
- R2: In 16-bit mode an odd-address byte access takes one cycle with cyc_addr_o[0]=1 and cyc_bhe_no=0. A write drives the byte on both lanes, and a read returns {8'h00, bus[15:8]}.
- R3: In 16-bit mode an even-address word access takes one cycle with cyc_addr_o[0]=0 and cyc_bhe_no=0. Write data goes out unchanged, and the read result is the bus word unchanged.
- R4: In 16-bit mode an odd-address word at X takes two cycles in this order. The first is at X with cyc_bhe_no=0 and the write low byte on both lanes. The second is at X+1, which is even, with cyc_bhe_no=1 and the write high byte on both lanes.
- R5: For an odd-address word read in 16-bit mode, bus[15:8] from the first cycle becomes result[7:0], and bus[7:0] from the second cycle becomes result[15:8].
- R6: In 8-bit mode (mode input 1) every cycle has cyc_bhe_no=1 and data on the low lane. A word takes two cycles, at X and then X+1, with the low byte first. A read gathers bus[7:0] of each cycle, the first into result[7:0] and the second into result[15:8].
- R7: The second-cycle address wraps modulo 2^20, so a word at FFFFF continues at 00000.
- R8: req_ack_o is a single-cycle pulse. It comes one cycle after the cyc_done_i of the last cycle and never while cyc_req_o is high.
- R9: cyc_req_o, the address, the lane enable, the direction and the write data stay unchanged until cyc_done_i.
- R10: During reset cyc_req_o and req_ack_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until acknowledged |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_word_i | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr_i | input | 20 | Byte address |
| req_wdata_i | input | 16 | Write data, right-justified |
| bus8_mode_i | input | 1 | 1 = 8-bit external bus |
| req_ack_o | output | 1 | Access complete pulse |
| req_rdata_o | output | 16 | Read result, valid with req_ack_o |
| cyc_req_o | output | 1 | External cycle request |
| cyc_addr_o | output | 20 | Cycle address including bit 0 |
| cyc_bhe_no | output | 1 | High-bank enable, active low |
| cyc_we_o | output | 1 | Cycle direction |
| cyc_wdata_o | output | 16 | Lane-steered write data |
| cyc_done_i | input | 1 | Sequencer ends the current cycle |
| cyc_rdata_i | input | 16 | Bus read data for the ending cycle |

## Verification
Two things can happen in the same clock edge. The completion of the first half of a split access can coincide with the switch to the second half's address and lanes. The completion of the last half can coincide with the merge into the result register, just before the acknowledge. The bench provokes both with zero-wait responses, then repeats the same accesses with several wait cycles. A responder model compares every cycle against a queue of expected cycles and checks that nothing changes while it is waiting. The requester side checks that the merged read word is correct in the acknowledge cycle, that the acknowledge lands exactly one cycle after the last done, and that accesses at the top address wrap to zero.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS0 = 2'd1,
    ST_BUS1 = 2'd2,
    ST_ACK  = 2'd3
  } bsplit_state_e;

  typedef enum logic [1:0] {
    ROUTE_LO   = 2'd0,
    ROUTE_HI   = 2'd1,
    ROUTE_WORD = 2'd2
  } lane_route_e;
endpackage

// File: rtl/bsplit_planner.sv
module bsplit_planner
  import bsplit_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_i,
  input  logic              mode8_i,
  input  logic              idx_i,
  output logic              two_cyc_o,
  output logic [ADDR_W-1:0] cyc_addr_o,
  output logic              bhe_no,
  output lane_route_e       route_o,
  output logic              half_o
);
  logic odd;
  logic [ADDR_W-1:0] addr_next;

  assign odd       = addr_i[0];
  assign addr_next = addr_i + ADDR_W'(1);
  assign two_cyc_o = mode8_i ? word_i : (word_i & odd);
  assign cyc_addr_o = idx_i ? addr_next : addr_i;

  always_comb begin
    route_o = ROUTE_LO;
    bhe_no  = 1'b1;
    half_o  = 1'b0;
    if (mode8_i) begin
      route_o = ROUTE_LO;
      bhe_no  = 1'b1;
      half_o  = idx_i;
    end else if (word_i && !odd) begin
      route_o = ROUTE_WORD;
      bhe_no  = 1'b0;
    end else if (word_i) begin
      // split: high lane first, then low lane of next even address
      route_o = idx_i ? ROUTE_LO : ROUTE_HI;
      bhe_no  = idx_i;
      half_o  = idx_i;
    end else begin
      route_o = odd ? ROUTE_HI : ROUTE_LO;
      bhe_no  = ~odd;
    end
  end
endmodule

// File: rtl/bsplit_steer.sv
module bsplit_steer
  import bsplit_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned N_LANES = 2
) (
  input  lane_route_e              route_i,
  input  logic                     half_i,
  input  logic [N_LANES*LANE_W-1:0] wdata_i,
  input  logic [N_LANES*LANE_W-1:0] bus_rdata_i,
  output logic [N_LANES*LANE_W-1:0] bus_wdata_o,
  output logic [LANE_W-1:0]         rd_byte_o
);
  logic [LANE_W-1:0] wr_byte;

  assign wr_byte = half_i ? wdata_i[LANE_W +: LANE_W] : wdata_i[0 +: LANE_W];

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign bus_wdata_o[g*LANE_W +: LANE_W] =
      (route_i == ROUTE_WORD) ? wdata_i[g*LANE_W +: LANE_W] : wr_byte;
  end

  assign rd_byte_o = (route_i == ROUTE_HI) ? bus_rdata_i[LANE_W +: LANE_W]
                                           : bus_rdata_i[0 +: LANE_W];
endmodule

// File: rtl/bsplit_ctrl.sv
module bsplit_ctrl
  import bsplit_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic two_cyc_i,
  input  logic cyc_done_i,
  output logic accept_o,
  output logic active_o,
  output logic idx_o,
  output logic ack_o
);
  bsplit_state_e state_q, state_d;

  assign accept_o = (state_q == ST_IDLE) && req_i;
  assign active_o = (state_q == ST_BUS0) || (state_q == ST_BUS1);
  assign idx_o    = (state_q == ST_BUS1);
  assign ack_o    = (state_q == ST_ACK);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_BUS0;
      ST_BUS0: if (cyc_done_i) state_d = two_cyc_i ? ST_BUS1 : ST_ACK;
      ST_BUS1: if (cyc_done_i) state_d = ST_ACK;
      ST_ACK:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  a_r8_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r8_ack_no_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !active_o);
  a_r9_hold_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && !cyc_done_i |=> active_o && $stable(idx_o));
endmodule

// File: rtl/byte_lane_splitter.sv
module byte_lane_splitter
  import bsplit_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic              req_word_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              bus8_mode_i,
  output logic              req_ack_o,
  output logic [DATA_W-1:0] req_rdata_o,
  output logic              cyc_req_o,
  output logic [ADDR_W-1:0] cyc_addr_o,
  output logic              cyc_bhe_no,
  output logic              cyc_we_o,
  output logic [DATA_W-1:0] cyc_wdata_o,
  input  logic              cyc_done_i,
  input  logic [DATA_W-1:0] cyc_rdata_i
);
  localparam int unsigned N_LANES = 2;
  localparam int unsigned LANE_W  = DATA_W / N_LANES;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, res_q;
  logic              we_q, word_q, mode8_q;
  logic              accept, active, idx, two_cyc, half;
  lane_route_e       route;
  logic [LANE_W-1:0] rd_byte;

  bsplit_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .two_cyc_i  (two_cyc),
    .cyc_done_i (cyc_done_i),
    .accept_o   (accept),
    .active_o   (active),
    .idx_o      (idx),
    .ack_o      (req_ack_o)
  );

  bsplit_planner #(.ADDR_W(ADDR_W)) u_plan (
    .addr_i     (addr_q),
    .word_i     (word_q),
    .mode8_i    (mode8_q),
    .idx_i      (idx),
    .two_cyc_o  (two_cyc),
    .cyc_addr_o (cyc_addr_o),
    .bhe_no     (cyc_bhe_no),
    .route_o    (route),
    .half_o     (half)
  );

  bsplit_steer #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_steer (
    .route_i     (route),
    .half_i      (half),
    .wdata_i     (wdata_q),
    .bus_rdata_i (cyc_rdata_i),
    .bus_wdata_o (cyc_wdata_o),
    .rd_byte_o   (rd_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      word_q  <= 1'b0;
      mode8_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      we_q    <= req_we_i;
      word_q  <= req_word_i;
      mode8_q <= bus8_mode_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
    end else if (accept) begin
      res_q <= '0;
    end else if (active && cyc_done_i) begin
      if (route == ROUTE_WORD)  res_q <= cyc_rdata_i;
      else if (half)            res_q[LANE_W +: LANE_W] <= rd_byte;
      else                      res_q[0 +: LANE_W] <= rd_byte;
    end
  end

  assign cyc_req_o   = active;
  assign cyc_we_o    = we_q;
  assign req_rdata_o = res_q;

  a_r9_cycle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_req_o && !cyc_done_i |=> cyc_req_o && $stable(cyc_addr_o)
      && $stable(cyc_bhe_no) && $stable(cyc_we_o) && $stable(cyc_wdata_o));
  a_r6_bus8_no_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_req_o && mode8_q |-> cyc_bhe_no);
  a_r1_lane_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_req_o && !mode8_q |-> !(cyc_addr_o[0] && cyc_bhe_no));
  a_r4_second_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_req_o && idx && !mode8_q |-> !cyc_addr_o[0] && cyc_bhe_no);
  a_r8_ack_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_ack_o) |-> $past(cyc_done_i) && $past(cyc_req_o));
endmodule

// File: tb/byte_lane_splitter_tb.sv
module byte_lane_splitter_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_ni;
  logic        req, we, word, m8;
  logic [19:0] addr;
  logic [15:0] wdata;
  logic        ack;
  logic [15:0] rdata;
  logic        cyc_req, cyc_bhe_n, cyc_we, done;
  logic [19:0] cyc_addr;
  logic [15:0] cyc_wdata, cyc_rdata;

  byte_lane_splitter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .req_we_i(we), .req_word_i(word),
    .req_addr_i(addr), .req_wdata_i(wdata), .bus8_mode_i(m8),
    .req_ack_o(ack), .req_rdata_o(rdata), .cyc_req_o(cyc_req),
    .cyc_addr_o(cyc_addr), .cyc_bhe_no(cyc_bhe_n), .cyc_we_o(cyc_we),
    .cyc_wdata_o(cyc_wdata), .cyc_done_i(done), .cyc_rdata_i(cyc_rdata)
  );

  typedef struct {
    logic [19:0] a;
    logic        bhe_n;
    logic        we;
    logic [15:0] wd;
  } exp_cyc_t;

  exp_cyc_t    exp_q[$];
  logic [7:0]  mem [logic [19:0]];
  int          checks = 0, failures = 0, cnt = 0;
  int          served = 0, last_done_cnt = 0, wait_n = 0;
  string       cur_tag = "R1";
  bit          finished = 1'b0;

  always @(posedge clk) cnt <= cnt + 1;

  function automatic logic [7:0] mrd(logic [19:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // responder + monitor: pops expected cycles, serves bus
  initial begin
    done = 1'b0;
    cyc_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_ni && cyc_req) begin
        exp_cyc_t e;
        logic [19:0] sa; logic sb, sw; logic [15:0] sd;
        if (exp_q.size() == 0) begin
          chk(0, cur_tag, "unexpected cycle", {12'h0, cyc_addr}, 0);
        end else begin
          e = exp_q.pop_front();
          chk(cyc_addr == e.a, cur_tag, "cycle addr", {12'h0, cyc_addr}, {12'h0, e.a});
          chk(cyc_bhe_n == e.bhe_n, cur_tag, "bhe_n", {31'h0, cyc_bhe_n}, {31'h0, e.bhe_n});
          chk(cyc_we == e.we, cur_tag, "we", {31'h0, cyc_we}, {31'h0, e.we});
          if (e.we) chk(cyc_wdata == e.wd, cur_tag, "lane wdata", {16'h0, cyc_wdata}, {16'h0, e.wd});
        end
        sa = cyc_addr; sb = cyc_bhe_n; sw = cyc_we; sd = cyc_wdata;
        for (int i = 0; i < wait_n; i++) begin
          @(negedge clk);
          chk(cyc_req && cyc_addr == sa && cyc_bhe_n == sb && cyc_we == sw && cyc_wdata == sd,
              "R9", "hold during wait", {12'h0, cyc_addr}, {12'h0, sa});
        end
        if (m8) begin
          cyc_rdata = {8'hEE, mrd(cyc_addr)};
          if (cyc_we) mem[cyc_addr] = cyc_wdata[7:0];
        end else begin
          cyc_rdata = {mrd({cyc_addr[19:1], 1'b1}), mrd({cyc_addr[19:1], 1'b0})};
          if (cyc_we) begin
            if (!cyc_bhe_n) mem[{cyc_addr[19:1], 1'b1}] = cyc_wdata[15:8];
            if (!cyc_addr[0]) mem[{cyc_addr[19:1], 1'b0}] = cyc_wdata[7:0];
          end
        end
        done = 1'b1;
        last_done_cnt = cnt;
        served++;
        @(negedge clk);
        done = 1'b0;
        cyc_rdata = '0;
      end
    end
  end

  task automatic access(bit w, bit wd_word, bit mode8, logic [19:0] a,
                        logic [15:0] d, int waits, string tag);
    logic [19:0] a1;
    logic [15:0] exp_rd;
    int n;
    a1 = a + 20'd1;
    n = 0;
    if (mode8) begin
      exp_q.push_back('{a, 1'b1, w, {d[7:0], d[7:0]}}); n++;
      if (wd_word) begin exp_q.push_back('{a1, 1'b1, w, {d[15:8], d[15:8]}}); n++; end
    end else if (!wd_word) begin
      exp_q.push_back('{a, ~a[0], w, {d[7:0], d[7:0]}}); n++;
    end else if (!a[0]) begin
      exp_q.push_back('{a, 1'b0, w, d}); n++;
    end else begin
      exp_q.push_back('{a, 1'b0, w, {d[7:0], d[7:0]}}); n++;
      exp_q.push_back('{a1, 1'b1, w, {d[15:8], d[15:8]}}); n++;
    end
    exp_rd = wd_word ? {mrd(a1), mrd(a)} : {8'h00, mrd(a)};
    @(negedge clk);
    cur_tag = tag; wait_n = waits; served = 0;
    we = w; word = wd_word; m8 = mode8; addr = a; wdata = d; req = 1'b1;
    do @(negedge clk); while (!ack);
    chk(served == n, tag, "cycle count", served, n);
    chk(cnt == last_done_cnt + 1, "R8", "ack timing", cnt, last_done_cnt + 1);
    chk(!cyc_req, "R8", "ack while bus busy", {31'h0, cyc_req}, 0);
    if (!w) chk(rdata == exp_rd, tag, "read result", {16'h0, rdata}, {16'h0, exp_rd});
    req = 1'b0;
    @(negedge clk);
    chk(!ack, "R8", "ack single pulse", {31'h0, ack}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; req = 1'b0; we = 1'b0; word = 1'b0; m8 = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk(!cyc_req && !ack, "R10", "reset outputs", {30'h0, cyc_req, ack}, 0);
    rst_ni = 1'b1;

    // 16-bit mode, zero wait then waits
    access(1, 0, 0, 20'h00010, 16'h77A5, 0, "R1");
    access(1, 0, 0, 20'h00011, 16'h993C, 2, "R2");
    access(0, 1, 0, 20'h00010, 16'h0000, 0, "R3");
    access(0, 0, 0, 20'h00010, 16'h0000, 1, "R1");
    access(0, 0, 0, 20'h00011, 16'h0000, 0, "R2");
    access(1, 1, 0, 20'h00100, 16'h1234, 3, "R3");
    access(0, 1, 0, 20'h00100, 16'h0000, 0, "R3");
    access(1, 1, 0, 20'h00021, 16'hBEEF, 0, "R4");
    access(0, 1, 0, 20'h00021, 16'h0000, 0, "R5");
    access(0, 1, 0, 20'h00021, 16'h0000, 3, "R5");
    access(0, 0, 0, 20'h00022, 16'h0000, 0, "R4");
    // wrap
    access(1, 1, 0, 20'hFFFFF, 16'hCAFE, 1, "R7");
    access(0, 0, 0, 20'h00000, 16'h0000, 0, "R7");
    access(0, 1, 0, 20'hFFFFF, 16'h0000, 2, "R7");
    // 8-bit mode
    access(1, 1, 1, 20'h00200, 16'h5566, 0, "R6");
    access(0, 1, 1, 20'h00200, 16'h0000, 2, "R6");
    access(0, 1, 1, 20'h00201, 16'h0000, 0, "R6");
    access(1, 0, 1, 20'h00301, 16'h00AB, 1, "R6");
    access(0, 0, 1, 20'h00301, 16'h0000, 0, "R6");
    access(0, 1, 1, 20'hFFFFF, 16'h0000, 0, "R7");
    // back to 16-bit: check 8-bit writes landed per address
    access(0, 1, 0, 20'h00200, 16'h0000, 0, "R6");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "leftover expected cycles", exp_q.size(), 0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule